// File: doc/BRIEF.md
# Edge-Select Interrupting GPIO Port

A sixteen-pin general-purpose I/O port attached to a plain 16-bit register bus. Every pin has its own output latch, a direction bit, a polarity bit choosing whether a rising or a falling transition counts as an event, and a mask bit. Incoming pin levels pass through a synchronizer. A selected transition on an unmasked input pin sets a sticky status bit. Software clears status bits by writing ones to them. One registered, level-sensitive interrupt line summarises the status register.

Software configures a pin as an output by clearing its direction bit. From then on the pin drives its latched value and asserts its output enable. The sampled input levels can be read back through a pin-enable register, which works as a read gate. Only full-width accesses, with both byte lanes enabled, reach the registers.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, offsets 0x04 (output latch), 0x08 (direction), 0x0C (polarity), 0x10 (mask) and 0x18 (pin enable) read 0xFFFF. Offsets 0x00 (input data) and 0x14 (status) read 0x0000. `irq` is low and `pin_oe` is 0x0000.
- R2: A direction bit of 0 makes the pin an output: `pin_oe` is the inverse of the direction register, and `pin_out` shows the latch bit only where the direction bit is 0 (zero elsewhere). The change is visible in the cycle after the write that causes it.
- R3: A polarity bit of 1 selects a rising transition and 0 selects a falling transition. A selected transition on an input pin whose mask bit is 0 sets that pin's bit in the status register (0x14).
- R4: A pin whose mask bit is 1, or whose direction bit is 0, never sets its status bit.
- R5: A full write to 0x14 clears every status bit written as 1 and leaves the other bits unchanged. `irq` stays high while any status bit remains set and falls only once none is set.
- R6: `irq` is registered. It rises one clock after the status bit is captured, and it is high in every cycle that follows a cycle with any status bit set.
- R7: A read of 0x00 returns the synchronized input levels ANDed with the pin-enable register.
- R8: An access with `bus_be` other than 2'b11 is ignored on write and returns zero on read.
- R9: Reads of unmapped offsets return zero, and writes to unmapped offsets change no register.
- R10: A transition of the opposite polarity to the one selected does not set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_be | input | 2 | Byte-lane enables; only 2'b11 is honoured |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a single pin change that sets status on some pins but not on others. Which pins set status depends on the polarity, mask and direction bits together. The bench programs those three registers to different byte patterns and then flips all sixteen pins at once, in both directions. The status readback then has to match exactly the bits that the three registers qualify, and no others. The interrupt timing is then checked cycle by cycle, both when an event is captured and when the status is cleared in two partial writes.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   localparam int unsigned OFS_W = 8;
   localparam logic [OFS_W-1:0] OFS_DIN  = 8'h00;
   localparam logic [OFS_W-1:0] OFS_DOUT = 8'h04;
   localparam logic [OFS_W-1:0] OFS_DIR  = 8'h08;
   localparam logic [OFS_W-1:0] OFS_POL  = 8'h0C;
   localparam logic [OFS_W-1:0] OFS_MSK  = 8'h10;
   localparam logic [OFS_W-1:0] OFS_STS  = 8'h14;
   localparam logic [OFS_W-1:0] OFS_PEN  = 8'h18;

   typedef struct packed {
      logic [15:0] dout;
      logic [15:0] dir;
      logic [15:0] pol;
      logic [15:0] msk;
      logic [15:0] pen;
   } cfg_t;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];
   logic [W-1:0] prev_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chain[STAGES-1];

   assign q      = chain[STAGES-1];
   assign q_prev = prev_q;
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
   import gpio_edge_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [OFS_W-1:0] bus_addr,
   input  logic [1:0]       bus_be,
   input  logic [W-1:0]     bus_wdata,
   output logic [W-1:0]     bus_rdata,
   input  logic [W-1:0]     din_sync,
   input  logic [W-1:0]     status,
   output cfg_t             cfg,
   output logic [W-1:0]     sts_clr
);
   localparam logic [W-1:0] ONES = {W{1'b1}};

   logic full, wr_en;
   assign full  = (bus_be == 2'b11);
   assign wr_en = bus_sel && bus_wr && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.dout <= ONES;
         cfg.dir  <= ONES;
         cfg.pol  <= ONES;
         cfg.msk  <= ONES;
         cfg.pen  <= ONES;
      end else if (wr_en) begin
         case (bus_addr)
            OFS_DOUT: cfg.dout <= bus_wdata;
            OFS_DIR:  cfg.dir  <= bus_wdata;
            OFS_POL:  cfg.pol  <= bus_wdata;
            OFS_MSK:  cfg.msk  <= bus_wdata;
            OFS_PEN:  cfg.pen  <= bus_wdata;
            default: ;
         endcase
      end
   end

   assign sts_clr = (wr_en && bus_addr == OFS_STS) ? bus_wdata : '0;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr && full) begin
         case (bus_addr)
            OFS_DIN:  bus_rdata = din_sync & cfg.pen;
            OFS_DOUT: bus_rdata = cfg.dout;
            OFS_DIR:  bus_rdata = cfg.dir;
            OFS_POL:  bus_rdata = cfg.pol;
            OFS_MSK:  bus_rdata = cfg.msk;
            OFS_STS:  bus_rdata = status;
            OFS_PEN:  bus_rdata = cfg.pen;
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prev,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] dir,
   input  logic [W-1:0] msk,
   input  logic [W-1:0] clr,
   output logic [W-1:0] status,
   output logic         irq
);
   logic [W-1:0] hit;
   logic [W-1:0] sts_q;
   logic         irq_q;

   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         logic rise, fall;
         assign rise   = cur[i] & ~prev[i];
         assign fall   = ~cur[i] & prev[i];
         assign hit[i] = (pol[i] ? rise : fall) & dir[i] & ~msk[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sts_q <= '0;
         irq_q <= 1'b0;
      end else begin
         sts_q <= (sts_q & ~clr) | hit;
         irq_q <= |sts_q;
      end

   assign status = sts_q;
   assign irq    = irq_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_edge_pkg::*;
#(
   parameter int unsigned W           = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_sel,
   input  logic         bus_wr,
   input  logic [7:0]   bus_addr,
   input  logic [1:0]   bus_be,
   input  logic [15:0]  bus_wdata,
   output logic [15:0]  bus_rdata,
   input  logic [15:0]  pin_in,
   output logic [15:0]  pin_out,
   output logic [15:0]  pin_oe,
   output logic         irq
);
   generate
      if (W != 16) begin : g_w_chk
         $error("gpio_edge_port: W must equal the 16-bit bus width");
      end
   endgenerate

   cfg_t         cfg;
   logic [W-1:0] din_sync, din_prev, status, sts_clr;

   gpio_edge_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_sync), .q_prev(din_prev)
   );

   gpio_edge_regs #(.W(W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .din_sync(din_sync), .status(status),
      .cfg(cfg), .sts_clr(sts_clr)
   );

   gpio_edge_detect #(.W(W)) u_det (
      .clk(clk), .rst_n(rst_n), .cur(din_sync), .prev(din_prev),
      .pol(cfg.pol), .dir(cfg.dir), .msk(cfg.msk), .clr(sts_clr),
      .status(status), .irq(irq)
   );

   assign pin_oe  = ~cfg.dir;
   assign pin_out = cfg.dout & ~cfg.dir;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_sel,
   input logic        bus_wr,
   input logic [1:0]  bus_be,
   input logic [15:0] status,
   input logic [15:0] msk,
   input logic [15:0] dir,
   input logic [15:0] pin_out,
   input logic [15:0] pin_oe,
   input logic        irq
);
   // R6
   irq_follows_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|status) |=> irq);

   // R5
   irq_fall_only_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(status) == 16'h0000));

   // R4
   masked_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status) & ($past(msk) | ~$past(dir))) == 16'h0000));

   // R8
   narrow_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_be != 2'b11) |=> $stable(dir));

   // R2
   drive_only_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == 16'h0000));
endmodule

bind gpio_edge_port gpio_edge_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_be(bus_be), .status(status), .msk(cfg.msk), .dir(cfg.dir),
   .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/gpio_edge_port_tb_top.sv
module gpio_edge_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_be = 2'b11;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   gpio_edge_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 2'b11;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d, input logic [1:0] be = 2'b11);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
      #1 d = bus_rdata;
      bus_sel = 1'b0; bus_be = 2'b11;
   endtask

   task automatic drive_pins(input logic [15:0] v, input int cycles);
      @(negedge clk);
      pin_in = v;
      repeat (cycles) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      rd(8'h00, d); check("R1 din",  d, 16'h0000);
      rd(8'h04, d); check("R1 dout", d, 16'hFFFF);
      rd(8'h08, d); check("R1 dir",  d, 16'hFFFF);
      rd(8'h0C, d); check("R1 pol",  d, 16'hFFFF);
      rd(8'h10, d); check("R1 msk",  d, 16'hFFFF);
      rd(8'h14, d); check("R1 sts",  d, 16'h0000);
      rd(8'h18, d); check("R1 pen",  d, 16'hFFFF);
      check("R1 irq", {15'd0, irq}, 16'h0000);
      check("R1 oe",  pin_oe, 16'h0000);
   endtask

   task automatic t_direction();
      wr(8'h04, 16'h00A5);
      wr(8'h08, 16'hFF00);
      check("R2 oe",  pin_oe,  16'h00FF);
      check("R2 out", pin_out, 16'h00A5);
      wr(8'h04, 16'h1234);
      check("R2 out latch", pin_out, 16'h0034);
      wr(8'h08, 16'hFFFF);
      check("R2 out released", pin_out, 16'h0000);
      check("R2 oe released",  pin_oe,  16'h0000);
   endtask

   task automatic t_edges();
      logic [15:0] d;
      wr(8'h0C, 16'h00FF);
      wr(8'h10, 16'h0000);
      @(negedge clk);
      pin_in = 16'hFFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R6 irq not yet", {15'd0, irq}, 16'h0000);
      rd(8'h14, d); check("R3 rise / R10 no fall", d, 16'h00FF);
      check("R6 irq one later", {15'd0, irq}, 16'h0001);
      drive_pins(16'h0000, 4);
      rd(8'h14, d); check("R3 fall", d, 16'hFFFF);
   endtask

   task automatic t_clear();
      logic [15:0] d;
      wr(8'h14, 16'h00FF);
      rd(8'h14, d); check("R5 partial clear", d, 16'hFF00);
      @(negedge clk);
      check("R5 irq held", {15'd0, irq}, 16'h0001);
      wr(8'h14, 16'hFF00);
      rd(8'h14, d); check("R5 full clear", d, 16'h0000);
      check("R5 irq low", {15'd0, irq}, 16'h0000);
   endtask

   task automatic t_mask();
      logic [15:0] d;
      wr(8'h0C, 16'hFFFF);
      wr(8'h10, 16'h0F0F);
      wr(8'h08, 16'hFF00);
      drive_pins(16'hFFFF, 5);
      rd(8'h14, d); check("R4 mask and dir", d, 16'hF000);
      wr(8'h14, 16'hFFFF);
      rd(8'h14, d); check("R5 clear", d, 16'h0000);
   endtask

   task automatic t_pinen();
      logic [15:0] d;
      wr(8'h10, 16'hFFFF);
      wr(8'h08, 16'hFFFF);
      drive_pins(16'h3C3C, 4);
      wr(8'h18, 16'h0FF0);
      rd(8'h00, d); check("R7 gated", d, 16'h0C30);
      wr(8'h18, 16'hFFFF);
      rd(8'h00, d); check("R7 open", d, 16'h3C3C);
   endtask

   task automatic t_narrow();
      logic [15:0] d;
      wr(8'h08, 16'h0000, 2'b01);
      wr(8'h08, 16'h0000, 2'b10);
      rd(8'h08, d); check("R8 write ignored", d, 16'hFFFF);
      rd(8'h08, d, 2'b10); check("R8 narrow read", d, 16'h0000);
      check("R8 oe", pin_oe, 16'h0000);
   endtask

   task automatic t_unmapped();
      logic [15:0] d;
      wr(8'h1C, 16'h0000);
      wr(8'h02, 16'h0000);
      rd(8'h1C, d); check("R9 read zero", d, 16'h0000);
      rd(8'h04, d); check("R9 dout kept", d, 16'h1234);
      rd(8'h0C, d); check("R9 pol kept",  d, 16'hFFFF);
      rd(8'h18, d); check("R9 pen kept",  d, 16'hFFFF);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_direction();
      t_edges();
      t_clear();
      t_mask();
      t_pinen();
      t_narrow();
      t_unmapped();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule